// File: doc/BRIEF.md
# Configurable Fast GPIO Front End

This block sits between a bank of pins and a real-time core. On the input side it brings thirty pins and two external status lines into the core's clock domain and presents them as one 32-bit read word. A mode input decides what that word means. It can show the pins as they are after synchronisation. It can show a 16-bit value captured on a strobe pin. It can show a 28-bit value assembled from a serial data and clock pair.

On the output side the core writes 32-bit words. In direct mode a write drives all 32 output pins on the next cycle. In serial mode a write starts a transfer: the word leaves on one pin, most significant bit first, next to a clock that the block generates on a second pin.

Changing either mode throws away all capture and shift state for that side, so a new mode always starts clean.

Top module: `fast_gpio_fe`

## Requirements
- R1: Out of reset, `rd_word_o`, `pins_o`, `shift_done_o` and `out_busy_o` are all zero.
- R2: In direct input mode (`in_mode_i` 2'b00, and 2'b11 behaves the same), `rd_word_o[29:0]` shows `pins_i` two rising clock edges after the pins change, through a two-flop synchroniser.
- R3: In every input mode, `rd_word_o[31:30]` shows `host_stat_i` with the same two-edge latency.
- R4: In capture mode (`in_mode_i` 2'b01), a rising edge on synchronised pin 16 latches pins 15:0 into `rd_word_o[15:0]`. `rd_word_o[29:16]` reads zero, and the captured value holds while the strobe stays high or low.
- R5: In shift-in mode (`in_mode_i` 2'b10), each rising edge on synchronised pin 1 shifts pin 0 into bit 0 of a 28-bit register, and the older bits move up. The register reads in `rd_word_o[27:0]`. After 28 shifts, `rd_word_o[28]` and `shift_done_o` set, and further clock edges are ignored.
- R6: In direct output mode (`out_mode_i` 0), `wr_en_i` loads `wr_word_i` onto `pins_o` from the next cycle on.
- R7: In shift-out mode (`out_mode_i` 1), a write while idle starts a transfer of 32 bits, most significant bit first, on `pins_o[0]`. The clock on `pins_o[1]` stays low for DIV cycles and then high for DIV cycles for each bit, and data is stable across each rising clock. `out_busy_o` stays high for 64*DIV cycles, and all other pins are zero. When idle, `pins_o` is zero.
- R8: A write made while a shift-out transfer is busy is ignored.
- R9: Any change of `in_mode_i` clears the capture register, the shift register, its count and the done flag. Any change of `out_mode_i` aborts and clears the output shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_mode_i | input | 2 | Input mode: 00 direct, 01 capture, 10 shift-in |
| out_mode_i | input | 1 | Output mode: 0 direct, 1 shift-out |
| pins_i | input | 30 | General input pins |
| host_stat_i | input | 2 | External status lines, read in the top two bits |
| wr_en_i | input | 1 | Output word write strobe |
| wr_word_i | input | 32 | Output word |
| rd_word_o | output | 32 | Input read word |
| pins_o | output | 32 | General output pins |
| shift_done_o | output | 1 | 28 bits have been shifted in |
| out_busy_o | output | 1 | Shift-out transfer in progress |

## Verification
The hardest case is a write that arrives in the middle of a shift-out transfer, because it has to overlap a 128-cycle transfer that the bench cannot see inside. The bench handles this with a scoreboard. Its driver queues the 32 expected bits of the first word, and the bench then writes a different word partway through. The monitor takes one bit on every rising edge of the serial clock, so any corruption from the stray write is reported. A second transfer is aborted by a mode change, and the bench then confirms that the shifter comes back idle and zero.

// File: rtl/fast_gpio_fe_pkg.sv
package fast_gpio_fe_pkg;
  typedef enum logic [1:0] {
    IN_DIRECT  = 2'b00,
    IN_CAPTURE = 2'b01,
    IN_SHIFT   = 2'b10,
    IN_RSVD    = 2'b11
  } in_mode_e;

  typedef enum logic {
    OUT_DIRECT = 1'b0,
    OUT_SHIFT  = 1'b1
  } out_mode_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_in_unit.sv
module gpio_in_unit
  import fast_gpio_fe_pkg::*;
#(
  parameter int CAP_W   = 16,
  parameter int SHIFT_W = 28
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  in_mode_e           mode_i,
  input  logic [CAP_W:0]     pin_s_i,   // synchronised pins, bit CAP_W is the strobe
  output logic [CAP_W-1:0]   cap_o,
  output logic [SHIFT_W-1:0] sh_o,
  output logic               done_o
);
  localparam int CNT_W = $clog2(SHIFT_W + 1);

  in_mode_e           mode_q;
  logic               stb_q, sck_q, done_q;
  logic [CAP_W-1:0]   cap_q;
  logic [SHIFT_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;

  logic mode_chg, stb_rise, sck_rise;
  assign mode_chg = (mode_i != mode_q);
  assign stb_rise = pin_s_i[CAP_W] & ~stb_q;
  assign sck_rise = pin_s_i[1] & ~sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= IN_DIRECT;
      stb_q  <= 1'b0;
      sck_q  <= 1'b0;
      cap_q  <= '0;
      sh_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      mode_q <= mode_i;
      stb_q  <= pin_s_i[CAP_W];
      sck_q  <= pin_s_i[1];
      if (mode_chg) begin
        cap_q  <= '0;
        sh_q   <= '0;
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else begin
        if (mode_i == IN_CAPTURE && stb_rise) cap_q <= pin_s_i[CAP_W-1:0];
        if (mode_i == IN_SHIFT && sck_rise && !done_q) begin
          sh_q  <= {sh_q[SHIFT_W-2:0], pin_s_i[0]};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(SHIFT_W - 1)) done_q <= 1'b1;
        end
      end
    end
  end

  assign cap_o  = cap_q;
  assign sh_o   = sh_q;
  assign done_o = done_q;
endmodule

// File: rtl/gpio_out_unit.sv
module gpio_out_unit
  import fast_gpio_fe_pkg::*;
#(
  parameter int OUT_W = 32,
  parameter int DIV   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  out_mode_e        mode_i,
  input  logic             wr_en_i,
  input  logic [OUT_W-1:0] wr_word_i,
  output logic [OUT_W-1:0] pins_o,
  output logic             busy_o
);
  localparam int BCNT_W = $clog2(OUT_W + 1);
  localparam int DCNT_W = $clog2(DIV + 1);

  out_mode_e         mode_q;
  logic [OUT_W-1:0]  out_q, sr_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic [DCNT_W-1:0] dcnt_q;
  logic              sck_q;
  logic              busy;

  assign busy = (bcnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= OUT_DIRECT;
      out_q  <= '0;
      sr_q   <= '0;
      bcnt_q <= '0;
      dcnt_q <= '0;
      sck_q  <= 1'b0;
    end else begin
      mode_q <= mode_i;
      if (wr_en_i && mode_i == OUT_DIRECT) out_q <= wr_word_i;
      if (mode_i != mode_q) begin
        sr_q   <= '0;
        bcnt_q <= '0;
        dcnt_q <= '0;
        sck_q  <= 1'b0;
      end else if (mode_i == OUT_SHIFT) begin
        if (!busy) begin
          if (wr_en_i) begin
            sr_q   <= wr_word_i;
            bcnt_q <= BCNT_W'(OUT_W);
            dcnt_q <= '0;
            sck_q  <= 1'b0;
          end
        end else if (dcnt_q == DCNT_W'(DIV - 1)) begin
          dcnt_q <= '0;
          if (sck_q) begin
            sck_q  <= 1'b0;
            sr_q   <= sr_q << 1;
            bcnt_q <= bcnt_q - 1'b1;
          end else begin
            sck_q <= 1'b1;
          end
        end else begin
          dcnt_q <= dcnt_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (mode_i == OUT_SHIFT) begin
      pins_o    = '0;
      pins_o[0] = sr_q[OUT_W-1];
      pins_o[1] = sck_q;
    end else begin
      pins_o = out_q;
    end
  end

  assign busy_o = busy;
endmodule

// File: rtl/fast_gpio_fe.sv
module fast_gpio_fe
  import fast_gpio_fe_pkg::*;
#(
  parameter int IN_W    = 30,
  parameter int STAT_W  = 2,
  parameter int CAP_W   = 16,
  parameter int SHIFT_W = 28,
  parameter int OUT_W   = 32,
  parameter int DIV     = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              in_mode_i,
  input  logic                    out_mode_i,
  input  logic [IN_W-1:0]         pins_i,
  input  logic [STAT_W-1:0]       host_stat_i,
  input  logic                    wr_en_i,
  input  logic [OUT_W-1:0]        wr_word_i,
  output logic [IN_W+STAT_W-1:0]  rd_word_o,
  output logic [OUT_W-1:0]        pins_o,
  output logic                    shift_done_o,
  output logic                    out_busy_o
);
  localparam int RD_W = IN_W + STAT_W;

  in_mode_e           in_mode;
  out_mode_e          out_mode;
  logic [RD_W-1:0]    sync_w;
  logic [IN_W-1:0]    pin_s;
  logic [STAT_W-1:0]  stat_s;
  logic [CAP_W-1:0]   cap;
  logic [SHIFT_W-1:0] sh;
  logic               done;
  logic [IN_W-1:0]    low;

  assign in_mode  = in_mode_e'(in_mode_i);
  assign out_mode = out_mode_e'(out_mode_i);

  gpio_sync #(.W(RD_W), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({host_stat_i, pins_i}),
    .q_o   (sync_w)
  );
  assign pin_s  = sync_w[IN_W-1:0];
  assign stat_s = sync_w[RD_W-1:IN_W];

  gpio_in_unit #(.CAP_W(CAP_W), .SHIFT_W(SHIFT_W)) u_in (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (in_mode),
    .pin_s_i(pin_s[CAP_W:0]),
    .cap_o  (cap),
    .sh_o   (sh),
    .done_o (done)
  );

  always_comb begin
    low = '0;
    unique case (in_mode)
      IN_CAPTURE: low[CAP_W-1:0] = cap;
      IN_SHIFT: begin
        low[SHIFT_W-1:0] = sh;
        low[SHIFT_W]     = done;
      end
      default: low = pin_s;
    endcase
  end
  assign rd_word_o    = {stat_s, low};
  assign shift_done_o = done;

  gpio_out_unit #(.OUT_W(OUT_W), .DIV(DIV)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (out_mode),
    .wr_en_i  (wr_en_i),
    .wr_word_i(wr_word_i),
    .pins_o   (pins_o),
    .busy_o   (out_busy_o)
  );
endmodule

// File: rtl/fast_gpio_fe_chk.sv
module fast_gpio_fe_chk #(
  parameter int IN_W    = 30,
  parameter int STAT_W  = 2,
  parameter int CAP_W   = 16,
  parameter int SHIFT_W = 28,
  parameter int OUT_W   = 32,
  parameter int DIV     = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [1:0]             in_mode_i,
  input logic                   out_mode_i,
  input logic [IN_W-1:0]        pins_i,
  input logic [STAT_W-1:0]      host_stat_i,
  input logic                   wr_en_i,
  input logic [OUT_W-1:0]       wr_word_i,
  input logic [IN_W+STAT_W-1:0] rd_word_o,
  input logic [OUT_W-1:0]       pins_o,
  input logic                   shift_done_o,
  input logic                   out_busy_o
);
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)             warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;

  // R2
  direct_in_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= 2'd2 && (in_mode_i == 2'b00 || in_mode_i == 2'b11))
      |-> rd_word_o[IN_W-1:0] == $past(pins_i, 2));

  // R3
  host_stat_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= 2'd2) |-> rd_word_o[IN_W+STAT_W-1:IN_W] == $past(host_stat_i, 2));

  // R4
  capture_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_mode_i == 2'b01) |-> rd_word_o[IN_W-1:CAP_W] == '0);

  // R9
  done_only_in_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_mode_i != 2'b10) |=> !shift_done_o);

  // R6
  direct_out_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= 2'd1 && !out_mode_i && $past(wr_en_i) && !$past(out_mode_i))
      |-> pins_o == $past(wr_word_i));

  // R7
  shift_idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_mode_i && !out_busy_o) |-> pins_o == '0);

  // R8
  busy_start_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= 2'd1 && $rose(out_busy_o)) |-> ($past(wr_en_i) && $past(out_mode_i)));
endmodule

bind fast_gpio_fe fast_gpio_fe_chk #(
  .IN_W(IN_W), .STAT_W(STAT_W), .CAP_W(CAP_W),
  .SHIFT_W(SHIFT_W), .OUT_W(OUT_W), .DIV(DIV)
) chk_i (.*);

// File: tb/fast_gpio_fe_tb_top.sv
module fast_gpio_fe_tb_top;
  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  in_mode = 2'b00;
  logic        out_mode = 1'b0;
  logic [29:0] pins_i = '0;
  logic [1:0]  host_stat = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_word = '0;
  logic [31:0] rd_word;
  logic [31:0] pins_o;
  logic        shift_done;
  logic        out_busy;

  int n_chk = 0, n_fail = 0;
  int sb_chk = 0, sb_fail = 0;
  bit mon_en = 1'b0;
  bit prev_sck = 1'b0;
  bit exp_q[$];

  always #2 clk = ~clk;  // 250 MHz

  fast_gpio_fe dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .in_mode_i(in_mode), .out_mode_i(out_mode),
    .pins_i(pins_i), .host_stat_i(host_stat), .wr_en_i(wr_en), .wr_word_i(wr_word),
    .rd_word_o(rd_word), .pins_o(pins_o), .shift_done_o(shift_done), .out_busy_o(out_busy)
  );

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic report(int extra);
    int tot, bad;
    tot = n_chk + sb_chk + extra;
    bad = n_fail + sb_fail + extra;
    $display("%0d/%0d checks passed", tot - bad, tot);
  endtask

  // scoreboard monitor: one bit per rising serial clock
  always @(negedge clk) begin
    if (mon_en && pins_o[1] && !prev_sck) begin
      sb_chk++;
      if (exp_q.size() == 0) begin
        sb_fail++;
        $display("FAIL R7 extra bit act=%0d exp=none", pins_o[0]);
      end else begin
        bit e;
        e = exp_q.pop_front();
        if (pins_o[0] != e) begin
          sb_fail++;
          $display("FAIL R7/R8 serial bit act=%0d exp=%0d", pins_o[0], e);
        end
      end
    end
    prev_sck = pins_o[1];
  end

  // driver: queue expected bits MSB first, then issue the write
  task automatic send_word(logic [31:0] w);
    for (int i = 31; i >= 0; i--) exp_q.push_back(w[i]);
    wr_word = w;
    wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic shift_bit(bit b);
    pins_i = {28'd0, 1'b0, b}; tick(3);
    pins_i = {28'd0, 1'b1, b}; tick(3);
    pins_i = {28'd0, 1'b0, b}; tick(3);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    $display("FAIL watchdog act=timeout exp=finish");
    report(1);
    $finish;
  end

  initial begin
    logic [27:0] sval;
    int cyc;
    sval = 28'h9E3_7A5C;
    tick(3);
    // R1 reset state
    check(rd_word == 0, "R1 rd_word", rd_word, 0);
    check(pins_o == 0, "R1 pins_o", pins_o, 0);
    check({shift_done, out_busy} == 0, "R1 flags", {30'd0, shift_done, out_busy}, 0);
    rst_ni = 1'b1;
    tick();

    // R2 / R3 direct input, two-edge latency
    pins_i = 30'h2AAA_5555; host_stat = 2'b10;
    tick();
    check(rd_word == 0, "R2 one edge", rd_word, 0);
    tick();
    check(rd_word == {2'b10, 30'h2AAA_5555}, "R2/R3 two edges", rd_word, {2'b10, 30'h2AAA_5555});
    in_mode = 2'b11; pins_i = 30'h1234_5678; host_stat = 2'b01; tick(2);
    check(rd_word == {2'b01, 30'h1234_5678}, "R2 mode 11 direct", rd_word, {2'b01, 30'h1234_5678});

    // R6 direct output
    wr_word = 32'hDEAD_BEEF; wr_en = 1'b1; tick(); wr_en = 1'b0;
    check(pins_o == 32'hDEAD_BEEF, "R6 write 1", pins_o, 32'hDEAD_BEEF);
    wr_word = 32'hA5A5_0F0F; wr_en = 1'b1; tick(); wr_en = 1'b0;
    check(pins_o == 32'hA5A5_0F0F, "R6 write 2", pins_o, 32'hA5A5_0F0F);

    // R4 capture
    in_mode = 2'b01; pins_i = 30'h2AA0_1234; tick(4);
    check(rd_word[29:0] == 0, "R4 no strobe edge", rd_word, 0);
    pins_i = 30'h2AA1_1234; tick(4);
    check(rd_word == {2'b01, 14'd0, 16'h1234}, "R4 strobe capture", rd_word, {2'b01, 14'd0, 16'h1234});
    pins_i = 30'h2AA1_BEEF; tick(4);
    check(rd_word[29:0] == 30'h1234, "R4 strobe held high", rd_word, 32'h1234);
    pins_i = 30'h0000_BEEF; tick(4);
    pins_i = 30'h0001_BEEF; tick(4);
    check(rd_word[29:0] == 30'hBEEF, "R4 second capture", rd_word, 32'hBEEF);

    // R5 shift-in
    in_mode = 2'b10; pins_i = '0; tick(3);
    check(rd_word[28:0] == 0, "R9 capture left, shift clear", rd_word, 0);
    for (int i = 27; i >= 1; i--) shift_bit(sval[i]);
    check(shift_done == 1'b0, "R5 not done at 27", {31'd0, shift_done}, 0);
    shift_bit(sval[0]);
    check(shift_done == 1'b1, "R5 done at 28", {31'd0, shift_done}, 1);
    check(rd_word[28:0] == {1'b1, sval}, "R5 shifted value", rd_word, {3'd0, 1'b1, sval});
    shift_bit(1'b1);
    check(rd_word[28:0] == {1'b1, sval}, "R5 extra clock ignored", rd_word, {3'd0, 1'b1, sval});

    // R9 input mode change clears
    in_mode = 2'b00; tick(3);
    in_mode = 2'b10; tick(2);
    check(rd_word[28:0] == 0 && !shift_done, "R9 shift cleared", rd_word, 0);
    in_mode = 2'b01; tick(2);
    check(rd_word[29:0] == 0, "R9 capture cleared", rd_word, 0);

    // R7 / R8 shift-out
    out_mode = 1'b1; tick(2);
    check(pins_o == 0, "R7 idle pins", pins_o, 0);
    mon_en = 1'b1;
    send_word(32'hC0FF_EE15);
    cyc = 0;
    while (out_busy && cyc < 1000) begin
      cyc++;
      if (cyc == 10) begin
        wr_word = 32'h1234_5678; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
      end else tick();
    end
    check(cyc == 64 * DIV, "R7 busy length", cyc, 64 * DIV);
    check(exp_q.size() == 0, "R7 all bits seen", exp_q.size(), 0);
    check(pins_o == 0, "R7 pins after transfer", pins_o, 0);
    send_word(32'h8000_0001);
    tick(64 * DIV + 2);
    check(exp_q.size() == 0 && !out_busy, "R7 second word", exp_q.size(), 0);

    // R9 output mode change aborts
    send_word(32'hFFFF_FFFF);
    tick(20);
    mon_en = 1'b0; tick();
    out_mode = 1'b0; tick(2);
    exp_q.delete();
    check(out_busy == 1'b0, "R9 abort busy", {31'd0, out_busy}, 0);
    check(pins_o == 32'hA5A5_0F0F, "R9 direct reg kept", pins_o, 32'hA5A5_0F0F);
    out_mode = 1'b1; tick(2);
    check(pins_o == 0 && !out_busy, "R9 shifter cleared", pins_o, 0);

    report(0);
    $finish;
  end
endmodule